// File: doc/BRIEF.md
# Event Ordering Monitor

This block watches a design and raises a flag whenever an ordering rule is broken. The rule is: after each trigger, event A must occur before event B. A trigger opens an obligation in the trigger cycle itself. A cycle that satisfies the ordering closes the obligation. A cycle in which B arrives first breaks it. Cycles with neither event leave the obligation open, for as long as that lasts.

Any number of triggers may arrive while earlier obligations are still open. All open obligations see the same inputs, so one state flop holds every open obligation at once. The automaton has one flop per state. Each state's next value is the OR of its incoming edge terms, and each edge term is an edge condition ANDed with the registered source state.

Two parameters pick the variant:
- `OVERLAP` selects the ordering rule. With `OVERLAP=1`, A and B arriving in the same cycle counts as in order. With `OVERLAP=0` (strict), A must come strictly earlier than B.
- `STRONG` selects whether the end-of-run flag matters. With `STRONG=1`, raising the end-of-run flag while an obligation is still open is also a violation.

The violation output is registered and pulses; it does not report a single verdict at the end of the run. All pins are plain control levels with no handshake, so the block never applies back-pressure and never stalls the design it watches.

Top module: `order_before_monitor`

## Requirements
- R1: `rst_n` is a synchronous reset, active low. While it is low and in the first cycle after it, `fail` is 0. Every open obligation is dropped, so a B after reset does not fail an obligation opened before reset.
- R2: A trigger cycle evaluates its own obligation in that same cycle. If `trig` and B (with A low) are high together, the obligation is violated. If `trig` and A (with B low) are high together, the obligation closes at once.
- R3: A violation seen in input cycle n drives `fail` to 1 in cycle n+1, after exactly one clock edge.
- R4: While an obligation is open, a cycle with both `ev_a` and `ev_b` at 0 keeps it open and produces no failure.
- R5: A cycle with `ev_a`=1 and `ev_b`=0 closes every open obligation. A later `ev_b` with no new trigger then produces no failure.
- R6: When `ev_a` and `ev_b` are both 1 while an obligation is open, the result depends on the variant. With `OVERLAP=0` it is a violation. With `OVERLAP=1` it closes the obligation without failure.
- R7: Several triggers before resolution merge. One resolving cycle settles all of them together and gives a single `fail` pulse, or none.
- R8: With `STRONG=0`, raising `eoe` has no effect on `fail`, even while an obligation is open.
- R9: With `STRONG=1`, `eoe`=1 in a cycle that leaves an obligation open (A and B both 0) gives `fail`=1 one cycle later. `eoe` with no open obligation, or in a cycle that closes the obligation, gives no failure.
- R10: `fail` is high only in cycles that follow a violating input cycle. Back-to-back violations keep it high, and one violation gives a one-cycle pulse.
- R11: With no trigger and no open obligation, activity on `ev_a`, `ev_b` or `eoe` leaves `fail` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trig | input | 1 | Opens an obligation starting this cycle |
| ev_a | input | 1 | Event that must come first |
| ev_b | input | 1 | Event that must not come first |
| eoe | input | 1 | End-of-run flag, normally 0 |
| fail | output | 1 | Registered violation pulse |

## Verification
On every cycle, the embedded properties check the following:
- B arriving ahead of A while an obligation is active raises `fail` one edge later.
- A same-cycle tie fails in the strict variant and stays silent in the overlapped one.
- `fail` stays low when nothing is active.
- The end-of-run flag behaves as its variant requires.

Only the bench scenarios can show the rest: obligations merging across several triggers, obligations surviving long quiet spells, and a reset dropping an open obligation. The bench also runs a strict-strong and an overlapped-weak instance side by side on the same stimulus, so every tie and end-of-run case is seen from both variants.

// File: rtl/order_before_pkg.sv
package order_before_pkg;
  // State indices of the one-hot automaton
  localparam int ST_OPEN = 0;   // an obligation is pending
  localparam int ST_BAD  = 1;   // final state: violation seen
  localparam int NUM_ST  = 2;

  typedef logic [NUM_ST-1:0] st_vec_t;

  // Decoded edge symbols for one cycle
  typedef struct packed {
    logic close_ok;   // ordering satisfied this cycle
    logic broken;     // B came first (or tie in strict mode)
    logic quiet;      // neither event
  } sym_t;
endpackage

// File: rtl/order_before_symbols.sv
module order_before_symbols
  import order_before_pkg::*;
#(
  parameter bit OVERLAP = 1'b0
) (
  input  logic ev_a,
  input  logic ev_b,
  output sym_t sym
);
  generate
    if (OVERLAP) begin : g_overlap
      // tie counts as in order
      always_comb begin
        sym.close_ok = ev_a;
        sym.broken   = ev_b & ~ev_a;
        sym.quiet    = ~ev_a & ~ev_b;
      end
    end else begin : g_strict
      // A must lead strictly; any B is a break
      always_comb begin
        sym.close_ok = ev_a & ~ev_b;
        sym.broken   = ev_b;
        sym.quiet    = ~ev_a & ~ev_b;
      end
    end
  endgenerate
endmodule

// File: rtl/order_before_edges.sv
module order_before_edges
  import order_before_pkg::*;
#(
  parameter bit STRONG = 1'b0
) (
  input  logic    trig,
  input  logic    eoe,
  input  sym_t    sym,
  input  st_vec_t st_q,
  output logic    active,
  output st_vec_t st_d
);
  logic hold_term;
  logic break_term;
  logic end_term;

  // Start state is always entered by the trigger; merged with pending set
  assign active     = trig | st_q[ST_OPEN];
  assign hold_term  = active & sym.quiet;
  assign break_term = active & sym.broken;

  generate
    if (STRONG) begin : g_strong
      assign end_term = eoe & hold_term;
    end else begin : g_weak
      assign end_term = 1'b0;
    end
  endgenerate

  always_comb begin
    st_d          = '0;
    st_d[ST_OPEN] = hold_term;
    st_d[ST_BAD]  = break_term | end_term;
  end
endmodule

// File: rtl/order_before_state_bank.sv
module order_before_state_bank
  import order_before_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  st_vec_t st_d,
  output st_vec_t st_q
);
  // One flop per automaton state, synchronous clear
  for (genvar i = 0; i < NUM_ST; i++) begin : g_ff
    always_ff @(posedge clk) begin
      if (!rst_n) st_q[i] <= 1'b0;
      else        st_q[i] <= st_d[i];
    end
  end
endmodule

// File: rtl/order_before_monitor.sv
module order_before_monitor
  import order_before_pkg::*;
#(
  parameter bit OVERLAP = 1'b0,
  parameter bit STRONG  = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic ev_a,
  input  logic ev_b,
  input  logic eoe,
  output logic fail
);
  sym_t    sym;
  st_vec_t st_d;
  st_vec_t st_q;
  logic    active;

  order_before_symbols #(.OVERLAP(OVERLAP)) u_sym (
    .ev_a (ev_a),
    .ev_b (ev_b),
    .sym  (sym)
  );

  order_before_edges #(.STRONG(STRONG)) u_edges (
    .trig   (trig),
    .eoe    (eoe),
    .sym    (sym),
    .st_q   (st_q),
    .active (active),
    .st_d   (st_d)
  );

  order_before_state_bank u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .st_d  (st_d),
    .st_q  (st_q)
  );

  assign fail = st_q[ST_BAD];

  // B ahead of A while active must be flagged one edge later
  p_b_first_fails_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active & ev_b & ~ev_a) |=> fail);

  // nothing pending and no trigger: no failure can follow
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig & !st_q[ST_OPEN]) |=> !fail);

  generate
    if (OVERLAP) begin : g_chk_ov
      p_tie_closes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (active & ev_a) |=> !fail);
    end else begin : g_chk_st
      p_tie_fails_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (active & ev_a & ev_b) |=> fail);
    end
    if (STRONG) begin : g_chk_strong
      p_eoe_open_fails_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (active & ~ev_a & ~ev_b & eoe) |=> fail);
    end else begin : g_chk_weak
      p_eoe_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (active & ~ev_a & ~ev_b) |=> !fail);
    end
  endgenerate
endmodule

// File: tb/order_before_monitor_tb.sv
module order_before_monitor_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig = 1'b0, ev_a = 1'b0, ev_b = 1'b0, eoe = 1'b0;
  logic fail_ss;   // strict, strong
  logic fail_ow;   // overlapped, weak
  int   n_chk = 0;
  int   n_bad = 0;
  int   cyc = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  order_before_monitor #(.OVERLAP(1'b0), .STRONG(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .trig(trig), .ev_a(ev_a), .ev_b(ev_b),
    .eoe(eoe), .fail(fail_ss));

  order_before_monitor #(.OVERLAP(1'b1), .STRONG(1'b0)) u_dut_alt (
    .clk(clk), .rst_n(rst_n), .trig(trig), .ev_a(ev_a), .ev_b(ev_b),
    .eoe(eoe), .fail(fail_ow));

  // {trig, a, b, eoe, expected fail strict-strong, expected fail overlap-weak}
  // expected values appear one edge after the vector is applied
  localparam int NV = 26;
  localparam logic [5:0] VEC [NV] = '{
    6'b011000,  // 0  R11 no obligation
    6'b001000,  // 1  R11
    6'b100000,  // 2  R4 open
    6'b000000,  // 3  R4 quiet keeps open
    6'b010000,  // 4  R5 close
    6'b001000,  // 5  R5 later B ignored
    6'b101011,  // 6  R2 trigger cycle with B
    6'b000000,  // 7  R10 pulse ends
    6'b111010,  // 8  R6 tie on trigger cycle
    6'b001000,  // 9  R6 nothing left open
    6'b100000,  // 10 R7 open
    6'b100000,  // 11 R7 second trigger merges
    6'b001011,  // 12 R7 single pulse for both
    6'b001000,  // 13 R10 no second pulse
    6'b100110,  // 14 R9 strong eoe while open / R8 weak ignores
    6'b000000,  // 15 R4 still open
    6'b010100,  // 16 R9 eoe on closing cycle
    6'b000100,  // 17 R9 eoe with nothing open
    6'b110000,  // 18 R2 trigger with A closes at once
    6'b001000,  // 19 R2
    6'b100000,  // 20 R6 open
    6'b011010,  // 21 R6 tie on pending obligation
    6'b001000,  // 22 R6
    6'b101011,  // 23 R10 back-to-back violations
    6'b101011,  // 24 R10
    6'b000000   // 25 R10
  };
  localparam int REQ [NV] = '{11,11,4,4,5,5,2,10,6,6,7,7,7,10,9,4,9,9,2,2,6,6,6,10,10,10};

  task automatic chk(input string req, input logic act, input logic exp, input string who);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: fail=%b expected %b", req, who, act, exp);
    end
  endtask

  task automatic drive(input logic t, input logic a, input logic b, input logic e);
    trig = t; ev_a = a; ev_b = b; eoe = e;
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 5000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: cycles=%0d expected <= 5000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk("R1", fail_ss, 1'b0, "in reset ss");
    chk("R1", fail_ow, 1'b0, "in reset ow");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", fail_ss, 1'b0, "after reset ss");

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2]);
      @(negedge clk);
      chk($sformatf("R%0d", REQ[i]), fail_ss, VEC[i][1], $sformatf("vec %0d ss", i));
      chk($sformatf("R%0d", REQ[i]), fail_ow, VEC[i][0], $sformatf("vec %0d ow", i));
    end

    // R1: obligation opened before reset is dropped
    drive(1, 0, 0, 0);
    @(negedge clk);
    drive(0, 0, 0, 0);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    drive(0, 0, 1, 1);
    @(negedge clk);
    chk("R1", fail_ss, 1'b0, "stale obligation ss");
    chk("R1", fail_ow, 1'b0, "stale obligation ow");

    // R4: long quiet spell then B still fails
    drive(1, 0, 0, 0);
    @(negedge clk);
    drive(0, 0, 0, 0);
    repeat (40) @(negedge clk);
    chk("R4", fail_ss, 1'b0, "long wait ss");
    drive(0, 0, 1, 0);
    @(negedge clk);
    chk("R3", fail_ss, 1'b1, "late B ss");
    chk("R3", fail_ow, 1'b1, "late B ow");
    drive(0, 0, 0, 0);
    @(negedge clk);
    chk("R10", fail_ss, 1'b0, "pulse width ss");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule